// File: doc/BRIEF.md
# Protection Switch Output Steering

This block decides who controls the output side of two channel pairs: pair 0 holds channels A and B, and pair 1 holds channels C and D. Each pair has a 2:1 output multiplexer and two per-channel output enables for its 3-state buffers. Either software register bits or one external protection-switch pin per pair drive these controls.

Two configuration bits choose the mode. With the enable bit clear, software drives every select and every output enable. With the enable bit set, the function bit picks what the pins steer. When it is clear, each pin steers its pair's multiplexer. When it is set, each pin steers its pair's two output enables. Software keeps control of whatever the pins do not steer.

The pins are asynchronous, so they pass through a synchronizer. All outputs come from registers, so a mode change cannot glitch them. The data buses and the pad buffers are outside this block.

Top module: `prot_sw_ctl`

## Requirements
- R1: While `rst_ni` is low, `sel_o` and `oe_o` are all zero. Zero on `oe_o` means high impedance.
- R2: With `cfg_en_i`=0, one clock edge after the inputs are sampled, `sel_o` equals `sw_sel_i` and `oe_o` equals `sw_oe_i`. Bit p of `sel_o` belongs to pair p. Bit c of `oe_o` belongs to channel c, where channels 2p and 2p+1 form pair p.
- R3: With `cfg_en_i`=1 and `cfg_func_i`=0, `sel_o[p]` follows the synchronized `prot_pin_i[p]`. A value of 0 selects the first channel of the pair (A or C) and 1 selects the second (B or D).
- R4: With `cfg_en_i`=1 and `cfg_func_i`=0, `oe_o` equals `sw_oe_i` one edge later.
- R5: With `cfg_en_i`=1 and `cfg_func_i`=1, `sel_o` equals `sw_sel_i` one edge later.
- R6: With `cfg_en_i`=1 and `cfg_func_i`=1, both `oe_o[2p]` and `oe_o[2p+1]` equal the inverse of the synchronized `prot_pin_i[p]`. A pin level of 0 drives the buffers and 1 puts them in high impedance.
- R7: With `cfg_en_i`=0, `cfg_func_i` has no effect on any output.
- R8: A change on `prot_pin_i` reaches the outputs on the third rising clock edge after it. That is two synchronizer stages plus the output register.
- R9: A change to `cfg_en_i` or `cfg_func_i` takes effect at the outputs on the first rising edge after it.
- R10: With `cfg_en_i`=0, `prot_pin_i` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Pin control enable (reset value of the register bit is 0) |
| cfg_func_i | input | 1 | 0: pins steer the multiplexers; 1: pins steer the output enables |
| sw_sel_i | input | NPAIR | Software multiplexer select, one bit per pair |
| sw_oe_i | input | 2*NPAIR | Software output enable, one bit per channel, 1 = drive |
| prot_pin_i | input | NPAIR | Asynchronous protection-switch pins, one per pair |
| sel_o | output | NPAIR | Multiplexer select per pair, 0 = first channel |
| oe_o | output | 2*NPAIR | Output enable per channel, 1 = drive |

## Verification
If the mode decode is wrong, a pin-driven control shows up where software should rule, or the reverse. A mismatching vector exposes this one edge after the vector is settled. If the synchronizer depth is wrong, the edge on which a pin change appears moves: a missing stage shows the change one edge early, and an extra stage holds it one edge too long. If the inversion on the pin-driven enables is lost, every pair flips between driving and high impedance. That is visible on the first edge after the function bit is set.

// File: rtl/prot_sw_pkg.sv
package prot_sw_pkg;
    typedef enum logic [1:0] {
        MODE_SOFT    = 2'd0,
        MODE_PIN_SEL = 2'd1,
        MODE_PIN_OE  = 2'd2
    } steer_mode_e;

    function automatic steer_mode_e decode_mode(input logic en, input logic func);
        if (!en)
            return MODE_SOFT;
        else if (!func)
            return MODE_PIN_SEL;
        else
            return MODE_PIN_OE;
    endfunction
endpackage

// File: rtl/prot_sw_sync.sv
module prot_sw_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            chain_q <= '0;
        else
            chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/prot_sw_pair.sv
module prot_sw_pair
    import prot_sw_pkg::*;
#(
    parameter int LANES = 2
) (
    input  steer_mode_e      mode_i,
    input  logic             sw_sel_i,
    input  logic [LANES-1:0] sw_oe_i,
    input  logic             pin_i,
    output logic             sel_o,
    output logic [LANES-1:0] oe_o
);
    always_comb begin
        sel_o = sw_sel_i;
        oe_o  = sw_oe_i;
        unique case (mode_i)
            MODE_PIN_SEL: sel_o = pin_i;
            MODE_PIN_OE:  oe_o  = {LANES{~pin_i}};
            default: ;
        endcase
    end
endmodule

// File: rtl/prot_sw_ctl.sv
module prot_sw_ctl
    import prot_sw_pkg::*;
#(
    parameter int NPAIR       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cfg_en_i,
    input  logic               cfg_func_i,
    input  logic [NPAIR-1:0]   sw_sel_i,
    input  logic [2*NPAIR-1:0] sw_oe_i,
    input  logic [NPAIR-1:0]   prot_pin_i,
    output logic [NPAIR-1:0]   sel_o,
    output logic [2*NPAIR-1:0] oe_o
);
    localparam int LANES = 2;
    localparam int NCH   = LANES * NPAIR;

    typedef struct packed {
        logic [NPAIR-1:0] sel;
        logic [NCH-1:0]   oe;
    } out_t;

    steer_mode_e      mode;
    logic [NPAIR-1:0] pin_sync;
    logic [NPAIR-1:0] sel_c;
    logic [NCH-1:0]   oe_c;
    out_t             out_d, out_q;

    prot_sw_sync #(.WIDTH(NPAIR), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (prot_pin_i),
        .sync_o  (pin_sync)
    );

    assign mode = decode_mode(cfg_en_i, cfg_func_i);

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        prot_sw_pair #(.LANES(LANES)) u_pair (
            .mode_i   (mode),
            .sw_sel_i (sw_sel_i[p]),
            .sw_oe_i  (sw_oe_i[p*LANES +: LANES]),
            .pin_i    (pin_sync[p]),
            .sel_o    (sel_c[p]),
            .oe_o     (oe_c[p*LANES +: LANES])
        );
    end

    always_comb begin
        out_d.sel = sel_c;
        out_d.oe  = oe_c;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign sel_o = out_q.sel;
    assign oe_o  = out_q.oe;
endmodule

// File: rtl/prot_sw_checker.sv
module prot_sw_checker #(
    parameter int NPAIR = 2
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               cfg_en_i,
    input logic               cfg_func_i,
    input logic [NPAIR-1:0]   sw_sel_i,
    input logic [2*NPAIR-1:0] sw_oe_i,
    input logic [NPAIR-1:0]   pin_sync,
    input logic [NPAIR-1:0]   sel_o,
    input logic [2*NPAIR-1:0] oe_o
);
    logic past_ok_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            past_ok_q <= 1'b0;
        else
            past_ok_q <= 1'b1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk_i)
        !rst_ni |-> (sel_o == '0 && oe_o == '0));

    assert_soft_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok_q && $past(!cfg_en_i)) |->
            (sel_o == $past(sw_sel_i) && oe_o == $past(sw_oe_i)));

    assert_pin_sel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok_q && $past(cfg_en_i && !cfg_func_i)) |-> (sel_o == $past(pin_sync)));

    assert_soft_oe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok_q && $past(cfg_en_i && !cfg_func_i)) |-> (oe_o == $past(sw_oe_i)));

    assert_soft_sel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok_q && $past(cfg_en_i && cfg_func_i)) |-> (sel_o == $past(sw_sel_i)));

    for (genvar p = 0; p < NPAIR; p++) begin : g_oe_chk
        assert_pin_oe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (past_ok_q && $past(cfg_en_i && cfg_func_i)) |->
                (oe_o[2*p] == !$past(pin_sync[p]) && oe_o[2*p+1] == !$past(pin_sync[p])));
    end
endmodule

bind prot_sw_ctl prot_sw_checker #(.NPAIR(NPAIR)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_en_i   (cfg_en_i),
    .cfg_func_i (cfg_func_i),
    .sw_sel_i   (sw_sel_i),
    .sw_oe_i    (sw_oe_i),
    .pin_sync   (pin_sync),
    .sel_o      (sel_o),
    .oe_o       (oe_o)
);

// File: tb/prot_sw_ctl_bench.sv
module prot_sw_ctl_bench;
    localparam int NPAIR = 2;
    localparam int NCH   = 2 * NPAIR;
    localparam int NVEC  = 8;

    logic             clk_i = 1'b0;
    logic             rst_ni = 1'b0;
    logic             cfg_en_i = 1'b0;
    logic             cfg_func_i = 1'b0;
    logic [NPAIR-1:0] sw_sel_i = '0;
    logic [NCH-1:0]   sw_oe_i = '0;
    logic [NPAIR-1:0] prot_pin_i = '0;
    logic [NPAIR-1:0] sel_o;
    logic [NCH-1:0]   oe_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk_i = ~clk_i;

    prot_sw_ctl #(.NPAIR(NPAIR), .SYNC_STAGES(2)) u_prot_sw_ctl (
        .clk_i, .rst_ni, .cfg_en_i, .cfg_func_i, .sw_sel_i, .sw_oe_i,
        .prot_pin_i, .sel_o, .oe_o
    );

    // {en, func, sw_sel[1:0], sw_oe[3:0], pin[1:0], exp_sel[1:0], exp_oe[3:0], tag[3:0]}
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 2'b01, 4'b1010, 2'b11, 2'b01, 4'b1010, 4'd0},  // R2, R10
        {1'b0, 1'b1, 2'b10, 4'b0110, 2'b01, 2'b10, 4'b0110, 4'd1},  // R7
        {1'b1, 1'b0, 2'b00, 4'b1111, 2'b10, 2'b10, 4'b1111, 4'd2},  // R3, R4
        {1'b1, 1'b0, 2'b11, 4'b0001, 2'b01, 2'b01, 4'b0001, 4'd2},  // R3, R4
        {1'b1, 1'b1, 2'b01, 4'b1111, 2'b00, 2'b01, 4'b1111, 4'd3},  // R5, R6
        {1'b1, 1'b1, 2'b10, 4'b0000, 2'b01, 2'b10, 4'b1100, 4'd3},  // R5, R6
        {1'b1, 1'b1, 2'b11, 4'b1111, 2'b10, 2'b11, 4'b0011, 4'd3},  // R5, R6
        {1'b1, 1'b1, 2'b00, 4'b1010, 2'b11, 2'b00, 4'b0000, 4'd3}   // R5, R6
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd0:    return "R2/R10";
            4'd1:    return "R7";
            4'd2:    return "R3/R4";
            default: return "R5/R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [NPAIR-1:0] esel, input logic [NCH-1:0] eoe);
        checks++;
        if (sel_o !== esel || oe_o !== eoe) begin
            fails++;
            $display("FAIL %s: sel=%b oe=%b expected sel=%b oe=%b", req, sel_o, oe_o, esel, eoe);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: outputs idle while reset is held
        cfg_en_i = 1'b1; cfg_func_i = 1'b1; sw_sel_i = '1; sw_oe_i = '1;
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        check("R1", '0, '0);
        rst_ni = 1'b1;
        cfg_en_i = 1'b0; cfg_func_i = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk_i);
            {cfg_en_i, cfg_func_i, sw_sel_i, sw_oe_i, prot_pin_i} = VEC[i][19:10];
            repeat (4) @(posedge clk_i);
            @(negedge clk_i);
            check(tag_name(VEC[i][3:0]), VEC[i][9:8], VEC[i][7:4]);
        end

        // R8: pin change latency in pin-selects-mux mode
        cfg_en_i = 1'b1; cfg_func_i = 1'b0; prot_pin_i = 2'b00; sw_oe_i = 4'b0101;
        repeat (4) @(posedge clk_i);
        @(negedge clk_i);
        prot_pin_i = 2'b11;
        @(posedge clk_i); @(negedge clk_i);
        check("R8 edge1", 2'b00, 4'b0101);
        @(posedge clk_i); @(negedge clk_i);
        check("R8 edge2", 2'b00, 4'b0101);
        @(posedge clk_i); @(negedge clk_i);
        check("R8 edge3", 2'b11, 4'b0101);

        // R9: function change effective on the next edge (pins settled at 11)
        sw_sel_i = 2'b01;
        cfg_func_i = 1'b1;
        @(posedge clk_i); @(negedge clk_i);
        check("R9 func", 2'b01, 4'b0000);
        cfg_en_i = 1'b0;
        @(posedge clk_i); @(negedge clk_i);
        check("R9 en", 2'b01, 4'b0101);

        // R10: pin toggles ignored in software mode, observed every edge
        for (int k = 0; k < 4; k++) begin
            prot_pin_i = 2'(k);
            @(posedge clk_i); @(negedge clk_i);
            check("R10", 2'b01, 4'b0101);
        end

        // R1: reset mid-run clears outputs
        rst_ni = 1'b0;
        #1;
        check("R1 async", '0, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule